// File: doc/BRIEF.md
# Dual-Mode Registered/Transparent Bus Driver

This block sits between a 12-bit input bus and two identical 12-bit output groups. A path-select input picks how data reaches the outputs. With the input low, the outputs show a bank of flip-flops that sample the input bus on each rising clock edge. With the input high, the input bus goes straight through to the outputs with no clock delay.

A load-scope input, active low, sets how much of the bank samples on an edge. When it is low, all twelve bits load. When it is high, only the four upper bits (indices 8 to 11) load, and the eight lower bits (indices 0 to 7) keep their values. The bank samples on every edge in both path modes, so it always holds the most recent capture.

An active-low drive-enable input controls both output groups. When it is high, each group reports itself invalid and its data is forced to zero. This stands in for a high-impedance bus without using internal tri-states. The drive enable has no effect on the bank.

Top module: `dm_bus_driver`

## Requirements
- R1: While `rst` is high at a rising edge, every bank bit clears to zero. With `path_sel_i`=0 and `drive_n_i`=0, the outputs read zero after that edge.
- R2: With `path_sel_i`=0, each output group shows the bank contents. A rising edge with `load_scope_n_i`=0 stores all of `din_i[11:0]`, and the stored value appears on the outputs right after that edge.
- R3: A rising edge with `load_scope_n_i`=1 stores only `din_i[11:8]`. Bank bits [7:0] keep the values they had before that edge.
- R4: With `path_sel_i`=1 and `drive_n_i`=0, each output group equals `din_i` in the same cycle, with no clock delay.
- R5: The bank keeps loading under the rules of R2 and R3 while `path_sel_i`=1. After a return to `path_sel_i`=0, the outputs show the latest capture.
- R6: Output group k occupies `dout_o[12k+11:12k]` (k = 0, 1). Both groups always carry the same value, and `dout_vld_o` is 2'b11 whenever `drive_n_i`=0.
- R7: With `drive_n_i`=1, `dout_vld_o` is 2'b00 and `dout_o` is all zero, whatever the value of `path_sel_i`.
- R8: `drive_n_i` has no effect on the bank. Data captured while the outputs are disabled appears once they are enabled again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset of the bank |
| path_sel_i | input | 1 | 0 selects the registered path, 1 selects the transparent path |
| load_scope_n_i | input | 1 | Active low: 0 loads all bits, 1 loads only bits [11:8] |
| drive_n_i | input | 1 | Active-low enable for both output groups |
| din_i | input | 12 | Input data bus |
| dout_o | output | 24 | Two copies of the selected data, group k at [12k+11:12k] |
| dout_vld_o | output | 2 | One bit per output group; 0 stands for high impedance |

## Verification
The bank properties assume that `din_i`, `load_scope_n_i` and `rst` are stable around each rising edge. The stimulus therefore changes every input on the falling edge and compares results one nanosecond after the rising edge. The transparent-path and disable properties relate port values sampled at the same edge, so they rely on the select and enable inputs not moving near that edge. Every bank property other than the reset property is switched off while `rst` is high, and the bench holds reset for two edges before it expects any bank value.

// File: rtl/dmbd_pkg.sv
package dmbd_pkg;

    typedef enum logic {
        PATH_REG = 1'b0,
        PATH_BUF = 1'b1
    } path_e;

    function automatic path_e decode_path(input logic sel);
        return sel ? PATH_BUF : PATH_REG;
    endfunction

endpackage

// File: rtl/dmbd_bank.sv
module dmbd_bank #(
    parameter int WIDTH  = 12,
    parameter int HOLD_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load_all_n,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);
    localparam int UPPER_W = WIDTH - HOLD_W;

    generate
        if (HOLD_W > 0) begin : g_hold_seg
            logic [HOLD_W-1:0] low_q;
            always_ff @(posedge clk) begin
                if (rst) begin
                    low_q <= '0;
                end else if (!load_all_n) begin
                    low_q <= d[HOLD_W-1:0];
                end
            end
            assign q[HOLD_W-1:0] = low_q;
        end

        if (UPPER_W > 0) begin : g_free_seg
            logic [UPPER_W-1:0] up_q;
            always_ff @(posedge clk) begin
                if (rst) begin
                    up_q <= '0;
                end else begin
                    up_q <= d[WIDTH-1:HOLD_W];
                end
            end
            assign q[WIDTH-1:HOLD_W] = up_q;
        end
    endgenerate

endmodule

// File: rtl/dmbd_path_sel.sv
module dmbd_path_sel
    import dmbd_pkg::*;
#(
    parameter int WIDTH = 12
) (
    input  path_e            path,
    input  logic [WIDTH-1:0] reg_d,
    input  logic [WIDTH-1:0] pass_d,
    output logic [WIDTH-1:0] sel_d
);
    always_comb begin
        unique case (path)
            PATH_REG: sel_d = reg_d;
            PATH_BUF: sel_d = pass_d;
            default:  sel_d = reg_d;
        endcase
    end

endmodule

// File: rtl/dmbd_fanout.sv
module dmbd_fanout #(
    parameter int WIDTH  = 12,
    parameter int COPIES = 2
) (
    input  logic                    drive_n,
    input  logic [WIDTH-1:0]        d,
    output logic [WIDTH*COPIES-1:0] y,
    output logic [COPIES-1:0]       vld
);
    generate
        for (genvar k = 0; k < COPIES; k++) begin : g_copy
            assign y[k*WIDTH +: WIDTH] = drive_n ? '0 : d;
            assign vld[k]              = ~drive_n;
        end
    endgenerate

endmodule

// File: rtl/dm_bus_driver.sv
module dm_bus_driver
    import dmbd_pkg::*;
#(
    parameter int WIDTH  = 12,
    parameter int HOLD_W = 8,
    parameter int COPIES = 2
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    path_sel_i,
    input  logic                    load_scope_n_i,
    input  logic                    drive_n_i,
    input  logic [WIDTH-1:0]        din_i,
    output logic [WIDTH*COPIES-1:0] dout_o,
    output logic [COPIES-1:0]       dout_vld_o
);
    logic [WIDTH-1:0] bank_q;
    logic [WIDTH-1:0] sel_d;
    path_e            path;

    assign path = decode_path(path_sel_i);

    dmbd_bank #(
        .WIDTH  (WIDTH),
        .HOLD_W (HOLD_W)
    ) u_bank (
        .clk        (clk),
        .rst        (rst),
        .load_all_n (load_scope_n_i),
        .d          (din_i),
        .q          (bank_q)
    );

    dmbd_path_sel #(
        .WIDTH (WIDTH)
    ) u_sel (
        .path   (path),
        .reg_d  (bank_q),
        .pass_d (din_i),
        .sel_d  (sel_d)
    );

    dmbd_fanout #(
        .WIDTH  (WIDTH),
        .COPIES (COPIES)
    ) u_fan (
        .drive_n (drive_n_i),
        .d       (sel_d),
        .y       (dout_o),
        .vld     (dout_vld_o)
    );

endmodule

// File: rtl/dmbd_checker.sv
module dmbd_checker #(
    parameter int WIDTH  = 12,
    parameter int HOLD_W = 8,
    parameter int COPIES = 2
) (
    input logic                    clk,
    input logic                    rst,
    input logic                    path_sel_i,
    input logic                    load_scope_n_i,
    input logic                    drive_n_i,
    input logic [WIDTH-1:0]        din_i,
    input logic [WIDTH-1:0]        bank_q,
    input logic [WIDTH*COPIES-1:0] dout_o,
    input logic [COPIES-1:0]       dout_vld_o
);
    // R1: reset clears the bank on the following edge
    a_r1_reset_clears: assert property (@(posedge clk)
        rst |=> (bank_q == '0));

    // R2: a full load stores every bit
    a_r2_full_load: assert property (@(posedge clk) disable iff (rst)
        !load_scope_n_i |=> (bank_q == $past(din_i)));

    // R3: a partial load keeps the lower segment
    a_r3_low_hold: assert property (@(posedge clk) disable iff (rst)
        load_scope_n_i |=> (bank_q[HOLD_W-1:0] == $past(bank_q[HOLD_W-1:0])));

    // R3: a partial load still stores the upper segment
    a_r3_up_load: assert property (@(posedge clk) disable iff (rst)
        load_scope_n_i |=> (bank_q[WIDTH-1:HOLD_W] == $past(din_i[WIDTH-1:HOLD_W])));

    // R4: the transparent path follows the input bus
    a_r4_pass_through: assert property (@(posedge clk) disable iff (rst)
        (path_sel_i && !drive_n_i) |-> (dout_o[WIDTH-1:0] == din_i));

    // R2, R5: the registered path shows the bank
    a_r5_reg_view: assert property (@(posedge clk) disable iff (rst)
        (!path_sel_i && !drive_n_i) |-> (dout_o[WIDTH-1:0] == bank_q));

    // R6: every copy matches group 0, and all groups are valid when driven
    a_r6_copies_equal: assert property (@(posedge clk) disable iff (rst)
        (dout_o == {COPIES{dout_o[WIDTH-1:0]}}));
    a_r6_valid_on: assert property (@(posedge clk) disable iff (rst)
        !drive_n_i |-> (dout_vld_o == {COPIES{1'b1}}));

    // R7: disabled groups report invalid with zero data
    a_r7_disabled: assert property (@(posedge clk) disable iff (rst)
        drive_n_i |-> ($countones(dout_vld_o) == 0 && dout_o == '0));

endmodule

bind dm_bus_driver dmbd_checker #(
    .WIDTH  (WIDTH),
    .HOLD_W (HOLD_W),
    .COPIES (COPIES)
) u_dmbd_checker (
    .clk            (clk),
    .rst            (rst),
    .path_sel_i     (path_sel_i),
    .load_scope_n_i (load_scope_n_i),
    .drive_n_i      (drive_n_i),
    .din_i          (din_i),
    .bank_q         (bank_q),
    .dout_o         (dout_o),
    .dout_vld_o     (dout_vld_o)
);

// File: tb/dm_bus_driver_bench.sv
`timescale 1ns/1ps
module dm_bus_driver_bench;
    localparam int W  = 12;
    localparam int HW = 8;
    localparam int NC = 2;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              path_sel_i = 1'b0;
    logic              load_scope_n_i = 1'b0;
    logic              drive_n_i = 1'b0;
    logic [W-1:0]      din_i = '0;
    logic [W*NC-1:0]   dout_o;
    logic [NC-1:0]     dout_vld_o;

    always #2 clk = ~clk;

    dm_bus_driver #(.WIDTH(W), .HOLD_W(HW), .COPIES(NC)) u_dm_bus_driver (
        .clk            (clk),
        .rst            (rst),
        .path_sel_i     (path_sel_i),
        .load_scope_n_i (load_scope_n_i),
        .drive_n_i      (drive_n_i),
        .din_i          (din_i),
        .dout_o         (dout_o),
        .dout_vld_o     (dout_vld_o)
    );

    int checks = 0;
    int errors = 0;
    logic done = 1'b0;
    logic [W-1:0] model = '0;

    logic [W*NC-1:0] exp_y_q[$];
    logic [NC-1:0]   exp_v_q[$];
    string           exp_tag_q[$];

    task automatic step(input logic r, input logic ps, input logic ld_n,
                        input logic dn, input logic [W-1:0] a, input string tag);
        logic [W-1:0] shown;
        @(negedge clk);
        rst = r; path_sel_i = ps; load_scope_n_i = ld_n; drive_n_i = dn; din_i = a;
        @(posedge clk);
        if (r) model = '0;
        else if (!ld_n) model = a;
        else model[W-1:HW] = a[W-1:HW];
        #1;
        shown = ps ? a : model;
        exp_y_q.push_back(dn ? '0 : {NC{shown}});
        exp_v_q.push_back(dn ? '0 : {NC{1'b1}});
        exp_tag_q.push_back(tag);
        #0.5;
    endtask

    initial begin : monitor
        forever begin
            logic [W*NC-1:0] ey;
            logic [NC-1:0]   ev;
            string           t;
            wait (exp_y_q.size() > 0);
            ey = exp_y_q.pop_front();
            ev = exp_v_q.pop_front();
            t  = exp_tag_q.pop_front();
            checks++;
            if (dout_o !== ey || dout_vld_o !== ev) begin
                errors++;
                $display("FAIL %s: dout=%h vld=%b expected dout=%h vld=%b",
                         t, dout_o, dout_vld_o, ey, ev);
            end
        end
    end

    initial begin : watchdog
        #20000;
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: run did not finish, actual=hung expected=done");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin : driver
        // R1: reset state
        step(1, 0, 0, 0, 12'hFFF, "R1");
        step(1, 0, 0, 0, 12'hFFF, "R1");
        // R2: full loads
        step(0, 0, 0, 0, 12'hA5C, "R2");
        step(0, 0, 0, 0, 12'h3F0, "R2");
        // R3: partial loads keep the lower eight bits
        step(0, 0, 1, 0, 12'hFFF, "R3");
        step(0, 0, 1, 0, 12'h000, "R3");
        // R4: transparent path
        step(0, 1, 1, 0, 12'h123, "R4");
        step(0, 1, 0, 0, 12'hABC, "R4");
        // R5: the bank keeps loading in transparent mode
        step(0, 1, 0, 0, 12'h555, "R5");
        step(0, 0, 1, 0, 12'h000, "R5");
        // R7: disabled in both modes
        step(0, 0, 0, 1, 12'h777, "R7");
        step(0, 1, 1, 1, 12'hFFF, "R7");
        // R8: captures continue while disabled, then become visible
        step(0, 0, 0, 1, 12'h9E7, "R8");
        step(0, 0, 1, 1, 12'h000, "R8");
        step(0, 0, 1, 0, 12'hC00, "R8");
        // R6: walking ones on both paths, both copies compared
        for (int i = 0; i < W; i++) begin
            step(0, i[0], i[1], 0, 12'(1) << i, "R6");
        end
        // R1: reset in mid-run
        step(1, 0, 1, 0, 12'hBAD, "R1");
        step(0, 0, 1, 0, 12'h000, "R1");
        wait (exp_y_q.size() == 0);
        #1;
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule